// File: doc/BRIEF.md
# Word-Addressed Wide Operand Store

This block holds four wide operand slots and one modulus register for a wide-word arithmetic engine. A host reaches all of them through a narrow 32-bit port. A single 9-bit address chooses between modulus space and operand space, names one of the four slots, and picks which 32-bit word to touch. The arithmetic engine sees the slot named by its own select, and the modulus, at full width and without any clock delay.

The engine hands back a full-width result with a single strobe, and that result replaces a whole slot in one cycle. A host write and a result write may aim at the same slot in the same cycle. In that case the result write is kept and a collision flag is raised for that cycle.

Top module: `wide_operand_store`

## Requirements
- R1: While reset is held, and right after it, every slot word, every modulus word and the host read data are zero.
- R2: A host write with address bit 8 clear stores the data word. Bits 7..6 of the address name the slot and bits 5..0 give the word index k. The word goes into bits [32k+31:32k] of that slot and no other bit of that slot changes. The new value is visible on the operand output from the next clock edge.
- R3: A host write with address bit 8 set stores the data into word k (bits 5..0) of the modulus. Address bits 7..6 make no difference to which word is written.
- R4: The host read data equals the addressed 32-bit word of the addressed slot. It appears one clock edge after the address is presented and shows the slot contents from before any write at that edge.
- R5: The modulus cannot be read by the host: an address with bit 8 set returns zero on the read data.
- R6: A word index at or above OP_WIDTH/32 is ignored on write, for both slots and the modulus, and reads back as zero.
- R7: When the load-result strobe is high at a clock edge, the full result input replaces the slot named by the result destination select.
- R8: When a host operand write and a result write name the same slot in the same cycle, the result is what is stored. The collision output is high during that cycle and at no other time.
- R9: When a host operand write and a result write name different slots in the same cycle, both take effect and the collision output stays low.
- R10: The operand output shows the slot chosen by the operand select, and it follows a change of that select in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | 9 | Host address: bit 8 selects the modulus, bits 7..6 the slot, bits 5..0 the word |
| hostWrData | input | 32 | Host write data |
| hostWrEn | input | 1 | Host write strobe |
| hostRdData | output | 32 | Registered host read data |
| opSel | input | 2 | Slot shown on the operand output |
| opOut | output | OP_WIDTH | Full-width selected slot |
| modOut | output | OP_WIDTH | Full-width modulus |
| resultIn | input | OP_WIDTH | Full-width result from the engine |
| loadResult | input | 1 | Result write strobe |
| resultDest | input | 2 | Slot receiving the result |
| collision | output | 1 | Same-slot host/result write clash this cycle |

## Verification
The assertions check four things on every cycle. A result load lands whole in its slot one edge later. A valid modulus write shows up in the matching word of the modulus. The host read data is zero after a modulus-space address. The modulus and the collision flag never move without a host modulus write or a pair of simultaneous writes. Some behaviours can only be shown by the bench's scenarios: word placement that leaves neighbouring words alone, the fact that bits 7..6 do not matter for the modulus, out-of-range indices that leave no trace, and which write survives a clash. The bench shows these by comparing against a shadow model of all five registers.

// File: rtl/wos_pkg.sv
package wos_pkg;
  localparam int HOST_W    = 32;
  localparam int NUM_SLOTS = 4;

  // strobes passed from the address decoder to the storage datapath
  typedef struct packed {
    logic       opWr;     // host write into a slot word (already loses to result)
    logic       modWr;    // host write into a modulus word
    logic       rdValid;  // addressed word is readable
    logic [1:0] opIdx;    // slot addressed by the host
    logic [5:0] wordIdx;  // word index addressed by the host
    logic       resWr;    // full-width result write
    logic [1:0] resIdx;   // slot receiving the result
  } wosStrobe_t;
endpackage

// File: rtl/wos_control.sv
module wos_control
  import wos_pkg::*;
#(
  parameter int OP_WIDTH = 256
) (
  input  logic [8:0] hostAddr,
  input  logic       hostWrEn,
  input  logic       loadResult,
  input  logic [1:0] resultDest,
  output wosStrobe_t strobe,
  output logic       collision
);
  localparam int NUM_WORDS = OP_WIDTH / HOST_W;

  logic modSpace;
  logic wordValid;
  logic sameSlot;

  always_comb begin
    modSpace  = hostAddr[8];
    wordValid = int'(hostAddr[5:0]) < NUM_WORDS;
    sameSlot  = !modSpace && (hostAddr[7:6] == resultDest);

    strobe.opIdx   = hostAddr[7:6];
    strobe.wordIdx = hostAddr[5:0];
    strobe.resIdx  = resultDest;
    strobe.resWr   = loadResult;
    // a result landing in the same slot overrides the host word
    strobe.opWr    = hostWrEn && !modSpace && wordValid && !(loadResult && sameSlot);
    strobe.modWr   = hostWrEn && modSpace && wordValid;
    strobe.rdValid = !modSpace && wordValid;

    collision = hostWrEn && loadResult && sameSlot;
  end
endmodule

// File: rtl/wos_datapath.sv
module wos_datapath
  import wos_pkg::*;
#(
  parameter int OP_WIDTH = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  wosStrobe_t          strobe,
  input  logic [HOST_W-1:0]   hostWrData,
  input  logic [OP_WIDTH-1:0] resultIn,
  input  logic [1:0]          opSel,
  output logic [OP_WIDTH-1:0] opOut,
  output logic [OP_WIDTH-1:0] modOut,
  output logic [HOST_W-1:0]   hostRdData
);
  localparam int NUM_WORDS = OP_WIDTH / HOST_W;

  logic [HOST_W-1:0] slotWord [NUM_SLOTS][NUM_WORDS];
  logic [HOST_W-1:0] modWord  [NUM_WORDS];
  logic [HOST_W-1:0] rdNext;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          slotWord[s][w] <= '0;
        else if (strobe.resWr && strobe.resIdx == 2'(s))
          slotWord[s][w] <= resultIn[w*HOST_W +: HOST_W];
        else if (strobe.opWr && strobe.opIdx == 2'(s) && strobe.wordIdx == 6'(w))
          slotWord[s][w] <= hostWrData;
      end
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : gMod
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        modWord[w] <= '0;
      else if (strobe.modWr && strobe.wordIdx == 6'(w))
        modWord[w] <= hostWrData;
    end
  end

  always_comb begin
    rdNext = '0;
    if (strobe.rdValid) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (strobe.wordIdx == 6'(w)) rdNext = slotWord[strobe.opIdx][w];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostRdData <= '0;
    else       hostRdData <= rdNext;
  end

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      opOut[w*HOST_W +: HOST_W]  = slotWord[opSel][w];
      modOut[w*HOST_W +: HOST_W] = modWord[w];
    end
  end
endmodule

// File: rtl/wide_operand_store.sv
module wide_operand_store
  import wos_pkg::*;
#(
  parameter int OP_WIDTH = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [8:0]          hostAddr,
  input  logic [31:0]         hostWrData,
  input  logic                hostWrEn,
  output logic [31:0]         hostRdData,
  input  logic [1:0]          opSel,
  output logic [OP_WIDTH-1:0] opOut,
  output logic [OP_WIDTH-1:0] modOut,
  input  logic [OP_WIDTH-1:0] resultIn,
  input  logic                loadResult,
  input  logic [1:0]          resultDest,
  output logic                collision
);
  wosStrobe_t strobe;

  wos_control #(.OP_WIDTH(OP_WIDTH)) uCtrl (
    .hostAddr  (hostAddr),
    .hostWrEn  (hostWrEn),
    .loadResult(loadResult),
    .resultDest(resultDest),
    .strobe    (strobe),
    .collision (collision)
  );

  wos_datapath #(.OP_WIDTH(OP_WIDTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostWrData(hostWrData),
    .resultIn  (resultIn),
    .opSel     (opSel),
    .opOut     (opOut),
    .modOut    (modOut),
    .hostRdData(hostRdData)
  );
endmodule

// File: rtl/wide_operand_store_chk.sv
module wide_operand_store_chk #(
  parameter int OP_WIDTH = 256
) (
  input logic                clk,
  input logic                rstN,
  input logic [8:0]          hostAddr,
  input logic [31:0]         hostWrData,
  input logic                hostWrEn,
  input logic [31:0]         hostRdData,
  input logic [1:0]          opSel,
  input logic [OP_WIDTH-1:0] opOut,
  input logic [OP_WIDTH-1:0] modOut,
  input logic [OP_WIDTH-1:0] resultIn,
  input logic                loadResult,
  input logic [1:0]          resultDest,
  input logic                collision
);
  localparam int NUM_WORDS = OP_WIDTH / 32;

  // R7: a loaded result appears whole in its slot one edge later
  a_r7_result_lands: assert property (@(posedge clk) disable iff (!rstN)
    loadResult ##1 (opSel == $past(resultDest)) |-> opOut == $past(resultIn));

  // R3: a valid modulus write shows in the matching modulus word
  a_r3_mod_word: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr[8] && int'(hostAddr[5:0]) < NUM_WORDS)
      |=> modOut[32*int'($past(hostAddr[5:0])) +: 32] == $past(hostWrData));

  // R5: modulus space reads back as zero
  a_r5_mod_unreadable: assert property (@(posedge clk) disable iff (!rstN)
    $past(hostAddr[8]) |-> hostRdData == 32'h0);

  // R3: modulus holds without a host modulus write
  a_r3_mod_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWrEn && hostAddr[8]) |=> $stable(modOut));

  // R8: collision only with both writes present in operand space
  a_r8_collision_cause: assert property (@(posedge clk) disable iff (!rstN)
    collision |-> (hostWrEn && loadResult && !hostAddr[8]));
endmodule

bind wide_operand_store wide_operand_store_chk #(.OP_WIDTH(OP_WIDTH)) uChk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrData(hostWrData),
  .hostWrEn(hostWrEn), .hostRdData(hostRdData), .opSel(opSel), .opOut(opOut),
  .modOut(modOut), .resultIn(resultIn), .loadResult(loadResult),
  .resultDest(resultDest), .collision(collision)
);

// File: tb/sim_wide_operand_store.sv
`timescale 1ns/1ps
module sim_wide_operand_store;
  localparam int W  = 256;
  localparam int NW = W / 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [8:0]   hostAddr = '0;
  logic [31:0]  hostWrData = '0;
  logic         hostWrEn = 1'b0;
  logic [31:0]  hostRdData;
  logic [1:0]   opSel = '0;
  logic [W-1:0] opOut, modOut;
  logic [W-1:0] resultIn = '0;
  logic         loadResult = 1'b0;
  logic [1:0]   resultDest = '0;
  logic         collision;

  int checks = 0;
  int errors = 0;
  logic [31:0] slotModel [4][NW];
  logic [31:0] modModel  [NW];

  always #10 clk = ~clk;

  wide_operand_store #(.OP_WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostWrEn(hostWrEn), .hostRdData(hostRdData), .opSel(opSel), .opOut(opOut),
    .modOut(modOut), .resultIn(resultIn), .loadResult(loadResult),
    .resultDest(resultDest), .collision(collision)
  );

  // table: address, data (index 8 and above is out of range for W=256)
  localparam logic [8:0]  VEC_ADDR [10] = '{9'h000, 9'h047, 9'h083, 9'h0C5,
                                            9'h100, 9'h1C7, 9'h00A, 9'h13F,
                                            9'h041, 9'h0C0};
  localparam logic [31:0] VEC_DATA [10] = '{32'hA5A5_0001, 32'h1234_5678,
                                            32'hDEAD_BEEF, 32'h0F0F_F0F0,
                                            32'hCAFE_0000, 32'h8000_0001,
                                            32'hFFFF_FFFF, 32'h7777_7777,
                                            32'h0BAD_F00D, 32'h5555_AAAA};

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] slotFlat(input int s);
    logic [W-1:0] v;
    for (int w = 0; w < NW; w++) v[w*32 +: 32] = slotModel[s][w];
    return v;
  endfunction

  function automatic logic [W-1:0] modFlat();
    logic [W-1:0] v;
    for (int w = 0; w < NW; w++) v[w*32 +: 32] = modModel[w];
    return v;
  endfunction

  task automatic hostWrite(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
    if (int'(a[5:0]) < NW) begin
      if (a[8]) modModel[a[5:0]] = d;
      else      slotModel[a[7:6]][a[5:0]] = d;
    end
  endtask

  task automatic hostRead(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWrEn = 1'b0;
    @(negedge clk);
    d = hostRdData;
  endtask

  function automatic logic [31:0] readExp(input logic [8:0] a);
    if (a[8] || int'(a[5:0]) >= NW) return 32'h0;
    return slotModel[a[7:6]][a[5:0]];
  endfunction

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    for (int s = 0; s < 4; s++) for (int w = 0; w < NW; w++) slotModel[s][w] = '0;
    for (int w = 0; w < NW; w++) modModel[w] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 modulus in reset", modOut, '0);
    check("R1 read data in reset", {224'h0, hostRdData}, '0);
    rstN = 1'b1;
    for (int s = 0; s < 4; s++) begin
      opSel = 2'(s); #1;
      check("R1 slot after reset", opOut, '0);
    end

    // table walk: R2, R3, R4, R5, R6
    for (int i = 0; i < 10; i++) begin
      hostWrite(VEC_ADDR[i], VEC_DATA[i]);
      opSel = VEC_ADDR[i][7:6]; #1;
      check("R2/R6 slot contents", opOut, slotFlat(VEC_ADDR[i][7:6]));
      check("R3/R6 modulus contents", modOut, modFlat());
      hostRead(VEC_ADDR[i], rd);
      check("R4/R5/R6 host read", {224'h0, rd}, {224'h0, readExp(VEC_ADDR[i])});
    end

    // R3: bits 7..6 ignored for modulus
    hostWrite(9'h1C2, 32'h1111_2222);
    hostWrite(9'h102, 32'h3333_4444);
    check("R3 modulus bits 7..6 ignored", modOut, modFlat());

    // R4: read shows contents before a same-edge write
    @(negedge clk);
    hostAddr = 9'h083; hostWrData = 32'h9999_0000; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
    check("R4 read before write", {224'h0, hostRdData}, {224'h0, 32'hDEAD_BEEF});
    slotModel[2][3] = 32'h9999_0000;
    hostRead(9'h083, rd);
    check("R4 read after write", {224'h0, rd}, {224'h0, 32'h9999_0000});

    // R7: result load
    @(negedge clk);
    resultIn = {8{32'h1357_9BDF}}; resultDest = 2'd3; loadResult = 1'b1;
    @(negedge clk);
    loadResult = 1'b0;
    for (int w = 0; w < NW; w++) slotModel[3][w] = 32'h1357_9BDF;
    opSel = 2'd3; #1;
    check("R7 result written", opOut, slotFlat(3));
    opSel = 2'd2; #1;
    check("R7 other slot untouched", opOut, slotFlat(2));

    // R10: combinational select
    opSel = 2'd1; #1;
    check("R10 select follows", opOut, slotFlat(1));

    // R8: same-slot clash
    @(negedge clk);
    hostAddr = 9'h040; hostWrData = 32'hEEEE_EEEE; hostWrEn = 1'b1;
    resultIn = {8{32'h2468_ACE0}}; resultDest = 2'd1; loadResult = 1'b1;
    #1;
    check("R8 collision high", {255'h0, collision}, {255'h0, 1'b1});
    @(negedge clk);
    hostWrEn = 1'b0; loadResult = 1'b0;
    for (int w = 0; w < NW; w++) slotModel[1][w] = 32'h2468_ACE0;
    opSel = 2'd1; #1;
    check("R8 result wins", opOut, slotFlat(1));
    check("R8 collision drops", {255'h0, collision}, '0);

    // R9: different slots both land
    @(negedge clk);
    hostAddr = 9'h005; hostWrData = 32'h0000_FACE; hostWrEn = 1'b1;
    resultIn = {8{32'hBBBB_0000}}; resultDest = 2'd2; loadResult = 1'b1;
    #1;
    check("R9 no collision", {255'h0, collision}, '0);
    @(negedge clk);
    hostWrEn = 1'b0; loadResult = 1'b0;
    slotModel[0][5] = 32'h0000_FACE;
    for (int w = 0; w < NW; w++) slotModel[2][w] = 32'hBBBB_0000;
    opSel = 2'd0; #1;
    check("R9 host word landed", opOut, slotFlat(0));
    opSel = 2'd2; #1;
    check("R9 result landed", opOut, slotFlat(2));

    // R8: modulus write with load is no clash
    @(negedge clk);
    hostAddr = 9'h180; hostWrData = 32'h4242_4242; hostWrEn = 1'b1;
    resultDest = 2'd2; loadResult = 1'b1;
    #1;
    check("R8 modulus write no collision", {255'h0, collision}, '0);
    @(negedge clk);
    hostWrEn = 1'b0; loadResult = 1'b0;
    modModel[0] = 32'h4242_4242;
    check("R3 modulus with load", modOut, modFlat());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule